// File: doc/BRIEF.md
# Register Write-Unlock Sequencer

This block stands between a simple register bus (address, data byte, write strobe) and a set of protected registers and non-volatile storage. It keeps two lock bits, a write-enable latch and a register-write-enable latch. Both are driven only by byte writes to one dedicated control address. A protected write goes downstream only when both bits are set, and setting both takes two ordered writes of distinct values. A single write of zero clears both bits again.

Software brackets every protected write in the same way. It writes the arm value and then the open value to the control address, performs its protected writes, and then writes zero to lock. Any protected write that arrives while the block is locked is dropped and flagged with a one-cycle reject pulse. Any protected write that arrives while it is unlocked is passed on one cycle later, together with a one-cycle accept pulse. The latch state is always visible on two output pins.

Top module: `reg_unlock_seq`

## Requirements
- R1: Synchronous reset (rst_n low at a rising edge) clears both latches, fwd_wr, acc_pulse and rej_pulse. The block comes out of reset locked.
- R2: A write of 0x02 to the control address 0x003F (the full 16-bit address, high byte 0x00) sets wr_en_latch from the following cycle.
- R3: A write of 0x06 to the control address sets reg_wr_latch only when wr_en_latch is already set. If wr_en_latch is clear, both latches stay unchanged, and reg_wr_latch is never set while wr_en_latch is clear.
- R4: A write of 0x00 to the control address clears both latches in the same edge, from any state.
- R5: A write of any other value to the control address leaves both latches unchanged. So does a write to any other address, including 0x013F.
- R6: A write to any address other than the control address while either latch is clear is discarded: fwd_wr stays low and rej_pulse is high for exactly one cycle after it.
- R7: A write to any address other than the control address while both latches are set appears one cycle later on fwd_addr/fwd_data with fwd_wr high, together with acc_pulse. Both are high for exactly one cycle.
- R8: Writes to the control address never raise fwd_wr, acc_pulse or rej_pulse.
- R9: A write of 0x02 while both latches are set leaves both latches set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Register address of the incoming write |
| bus_data | input | 8 | Data byte of the incoming write |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| fwd_addr | output | 16 | Address of the forwarded protected write |
| fwd_data | output | 8 | Data of the forwarded protected write |
| fwd_wr | output | 1 | Forwarded write strobe |
| wr_en_latch | output | 1 | Write-enable latch |
| reg_wr_latch | output | 1 | Register-write-enable latch |
| acc_pulse | output | 1 | One-cycle pulse: a protected write was accepted |
| rej_pulse | output | 1 | One-cycle pulse: a protected write was discarded |

## Verification
A wrong latch state shows directly on wr_en_latch and reg_wr_latch in the cycle after the control write that caused it. It also shows in the first protected write after that, which then produces the wrong one of acc_pulse or rej_pulse one cycle later. The directed scenarios walk the latches through every ordering of arm, open, lock and stray values, including open without arm and a near-miss address. Each scenario is followed by a protected write, so that a silent latch error is turned into a visible pulse error.

// File: rtl/wul_pkg.sv
// Package: shared types for the write-unlock sequencer.
// Assumes: one bus write is classified per cycle.
package wul_pkg;

    // Meaning of a write that hits the control address.
    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_LOCK  = 3'd1,
        CMD_ARM   = 3'd2,
        CMD_OPEN  = 3'd3,
        CMD_OTHER = 3'd4
    } ctrl_cmd_e;

    // State of the two lock bits.
    typedef struct packed {
        logic wel;
        logic rwel;
    } latch_state_t;

endpackage

// File: rtl/wul_decode.sv
// Module: wul_decode
// Classifies each bus write. A write to the control address becomes a
// command, and any other write is marked as protected.
// Assumes: the address compare covers every bit, including the high byte.
module wul_decode
    import wul_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int          DW        = 8,
    parameter logic [AW-1:0] CTRL_ADDR = 16'h003F,
    parameter logic [DW-1:0] LOCK_VAL  = 8'h00,
    parameter logic [DW-1:0] ARM_VAL   = 8'h02,
    parameter logic [DW-1:0] OPEN_VAL  = 8'h06
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic          wr,
    output logic          ctrl_wr,
    output logic          prot_wr,
    output ctrl_cmd_e     cmd
);

    logic hit_ctrl;

    // Address match and write-type split.
    always_comb begin
        hit_ctrl = (addr == CTRL_ADDR);
        ctrl_wr  = wr && hit_ctrl;
        prot_wr  = wr && !hit_ctrl;
    end

    // Map the data byte of a control write to a command.
    always_comb begin
        if (!ctrl_wr)              cmd = CMD_NONE;
        else if (data == LOCK_VAL) cmd = CMD_LOCK;
        else if (data == ARM_VAL)  cmd = CMD_ARM;
        else if (data == OPEN_VAL) cmd = CMD_OPEN;
        else                       cmd = CMD_OTHER;
    end

endmodule

// File: rtl/wul_latch.sv
// Module: wul_latch
// Holds the write-enable and register-write-enable bits and applies the
// ordered unlock rules: arm sets the first bit, open sets the second bit
// only when armed, and lock clears both.
// Assumes: cmd is CMD_NONE whenever there is no control write.
module wul_latch
    import wul_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_wr,
    input  ctrl_cmd_e cmd,
    output logic      wel,
    output logic      rwel
);

    latch_state_t cur, nxt;

    // Next-state rules for the two lock bits.
    always_comb begin
        nxt = cur;
        unique case (cmd)
            CMD_LOCK: nxt = '{wel: 1'b0, rwel: 1'b0};
            CMD_ARM:  nxt.wel = 1'b1;
            CMD_OPEN: if (cur.wel) nxt.rwel = 1'b1;
            default:  nxt = cur;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= '{wel: 1'b0, rwel: 1'b0};
        else        cur <= nxt;
    end

    assign wel  = cur.wel;
    assign rwel = cur.rwel;

    AST_RWEL_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        rwel |-> wel); // R3
    AST_OPEN_UNARMED_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && cmd == CMD_OPEN && !wel) |=> !rwel); // R3
    AST_LOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && cmd == CMD_LOCK) |=> (!wel && !rwel)); // R4
    AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && cmd == CMD_ARM) |=> wel); // R2
    AST_STRAY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr || cmd == CMD_OTHER) |=> ($stable(wel) && $stable(rwel))); // R5

endmodule

// File: rtl/wul_gate.sv
// Module: wul_gate
// Passes a protected write on, one cycle later, when both lock bits are
// set. Otherwise it drops the write. It raises a one-cycle accept or
// reject pulse for each protected write.
// Assumes: the lock bits seen are those in force before the current edge.
module wul_gate #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prot_wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic          wel,
    input  logic          rwel,
    output logic [AW-1:0] fwd_addr,
    output logic [DW-1:0] fwd_data,
    output logic          fwd_wr,
    output logic          acc,
    output logic          rej
);

    logic open_now;

    // Both bits must be set for a protected write to go through.
    always_comb open_now = wel && rwel;

    // Strobe and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_wr <= 1'b0;
            acc    <= 1'b0;
            rej    <= 1'b0;
        end else begin
            fwd_wr <= prot_wr && open_now;
            acc    <= prot_wr && open_now;
            rej    <= prot_wr && !open_now;
        end
    end

    // Payload registers, loaded only for an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_addr <= '0;
            fwd_data <= '0;
        end else if (prot_wr && open_now) begin
            fwd_addr <= addr;
            fwd_data <= data;
        end
    end

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && rej)); // R6
    AST_LOCKED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_wr && !(wel && rwel)) |=> (rej && !fwd_wr)); // R6
    AST_OPEN_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_wr && wel && rwel) |=> (fwd_wr && acc && fwd_data == $past(data))); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_wr |=> (!fwd_wr && !acc && !rej)); // R7

endmodule

// File: rtl/reg_unlock_seq.sv
// Module: reg_unlock_seq (top)
// Guards protected register writes behind a two-step unlock at one
// control address, and re-locks on a zero write.
// Assumes: at most one bus write per cycle, and a synchronous active-low reset.
module reg_unlock_seq
    import wul_pkg::*;
#(
    parameter int            AW        = 16,
    parameter int            DW        = 8,
    parameter logic [AW-1:0] CTRL_ADDR = 16'h003F,
    parameter logic [DW-1:0] LOCK_VAL  = 8'h00,
    parameter logic [DW-1:0] ARM_VAL   = 8'h02,
    parameter logic [DW-1:0] OPEN_VAL  = 8'h06
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic          bus_wr,
    output logic [AW-1:0] fwd_addr,
    output logic [DW-1:0] fwd_data,
    output logic          fwd_wr,
    output logic          wr_en_latch,
    output logic          reg_wr_latch,
    output logic          acc_pulse,
    output logic          rej_pulse
);

    logic      ctrl_wr;
    logic      prot_wr;
    ctrl_cmd_e cmd;

    wul_decode #(
        .AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR),
        .LOCK_VAL(LOCK_VAL), .ARM_VAL(ARM_VAL), .OPEN_VAL(OPEN_VAL)
    ) u_decode (
        .addr    (bus_addr),
        .data    (bus_data),
        .wr      (bus_wr),
        .ctrl_wr (ctrl_wr),
        .prot_wr (prot_wr),
        .cmd     (cmd)
    );

    wul_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .cmd     (cmd),
        .wel     (wr_en_latch),
        .rwel    (reg_wr_latch)
    );

    wul_gate #(.AW(AW), .DW(DW)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .prot_wr  (prot_wr),
        .addr     (bus_addr),
        .data     (bus_data),
        .wel      (wr_en_latch),
        .rwel     (reg_wr_latch),
        .fwd_addr (fwd_addr),
        .fwd_data (fwd_data),
        .fwd_wr   (fwd_wr),
        .acc      (acc_pulse),
        .rej      (rej_pulse)
    );

    AST_CTRL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTRL_ADDR) |=> (!fwd_wr && !acc_pulse && !rej_pulse)); // R8
    AST_STAY_OPEN_ON_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTRL_ADDR && bus_data == ARM_VAL && wr_en_latch && reg_wr_latch)
        |=> (wr_en_latch && reg_wr_latch)); // R9

endmodule

// File: tb/tb_reg_unlock_seq.sv
module tb_reg_unlock_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] fwd_addr;
    logic [7:0]  fwd_data;
    logic        fwd_wr, wr_en_latch, reg_wr_latch, acc_pulse, rej_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    reg_unlock_seq dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_wr(bus_wr), .fwd_addr(fwd_addr), .fwd_data(fwd_data), .fwd_wr(fwd_wr),
        .wr_en_latch(wr_en_latch), .reg_wr_latch(reg_wr_latch),
        .acc_pulse(acc_pulse), .rej_pulse(rej_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One-cycle write. Returns at the negedge after the capturing edge.
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_data = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic latches(input string req, input logic w, input logic r);
        chk({req, " wel"}, wr_en_latch, w);
        chk({req, " rwel"}, reg_wr_latch, r);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        latches("R1 reset", 1'b0, 1'b0);
        chk("R1 fwd_wr", fwd_wr, 1'b0);
        chk("R1 pulses", {acc_pulse, rej_pulse}, 2'b00);
    endtask

    task automatic t_locked_write();
        wr(16'h0010, 8'hA5);
        chk("R6 rej", rej_pulse, 1'b1);
        chk("R6 acc", acc_pulse, 1'b0);
        chk("R6 fwd_wr", fwd_wr, 1'b0);
        idle();
        chk("R6 rej one cycle", rej_pulse, 1'b0);
    endtask

    task automatic t_open_unarmed();
        wr(16'h003F, 8'h06);
        latches("R3 open unarmed", 1'b0, 1'b0);
        chk("R8 ctrl no pulse", {fwd_wr, acc_pulse, rej_pulse}, 3'b000);
        wr(16'h0020, 8'h11);
        chk("R6 after open unarmed", {fwd_wr, rej_pulse}, 2'b01);
    endtask

    task automatic t_arm_only();
        wr(16'h003F, 8'h02);
        latches("R2 arm", 1'b1, 1'b0);
        chk("R8 arm no pulse", {fwd_wr, acc_pulse, rej_pulse}, 3'b000);
        wr(16'h0021, 8'h22);
        chk("R6 armed only", {fwd_wr, acc_pulse, rej_pulse}, 3'b001);
    endtask

    task automatic t_stray();
        wr(16'h003F, 8'h04);
        latches("R5 value 04", 1'b1, 1'b0);
        wr(16'h003F, 8'hFF);
        latches("R5 value FF", 1'b1, 1'b0);
        wr(16'h013F, 8'h06);
        latches("R5 addr 013F", 1'b1, 1'b0);
        chk("R6 addr 013F rejected", {fwd_wr, rej_pulse}, 2'b01);
    endtask

    task automatic t_unlock_write_lock();
        wr(16'h003F, 8'h06);
        latches("R3 open armed", 1'b1, 1'b1);
        wr(16'h1234, 8'h5C);
        chk("R7 fwd_wr", fwd_wr, 1'b1);
        chk("R7 acc", acc_pulse, 1'b1);
        chk("R7 rej", rej_pulse, 1'b0);
        chk("R7 addr", fwd_addr, 16'h1234);
        chk("R7 data", fwd_data, 8'h5C);
        idle();
        chk("R7 one cycle", {fwd_wr, acc_pulse}, 2'b00);
        wr(16'h003F, 8'h02);
        latches("R9 rearm open", 1'b1, 1'b1);
        wr(16'h003F, 8'hFF);
        latches("R5 stray while open", 1'b1, 1'b1);
        wr(16'h003F, 8'h00);
        latches("R4 lock", 1'b0, 1'b0);
        chk("R8 lock no pulse", {fwd_wr, acc_pulse, rej_pulse}, 3'b000);
        wr(16'h1234, 8'h77);
        chk("R6 after lock", {fwd_wr, acc_pulse, rej_pulse}, 3'b001);
    endtask

    task automatic t_lock_from_arm();
        wr(16'h003F, 8'h02);
        wr(16'h003F, 8'h00);
        latches("R4 lock from arm", 1'b0, 1'b0);
    endtask

    task automatic t_reset_while_open();
        wr(16'h003F, 8'h02);
        wr(16'h003F, 8'h06);
        latches("R3 reopen", 1'b1, 1'b1);
        do_reset();
        latches("R1 reset while open", 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_locked_write();
        t_open_unarmed();
        t_arm_only();
        t_stray();
        t_unlock_write_lock();
        t_lock_from_arm();
        t_reset_while_open();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule